// File: doc/BRIEF.md
# Extensible DMA Byte Counter with Identification Readback

This block holds the byte count for a DMA transfer. Software writes a start count one byte at a time through a small register port. Any command whose top bit is set copies the start count into a live counter, and the counter then steps down by one for every transferred byte. A feature-enable input chooses the counter width. When the input is low, only the lower two bytes count and decide terminal count. When it is high, a third, upper byte joins them and the counter becomes 24 bits wide.

The address that holds the upper start byte can also return a fixed identification code, so software can detect which variant of the block it is talking to. The code is returned only when three things hold together: the DMA no-op command has been seen since reset, the feature-enable input is high, and that address has not been written since reset. In every other case, a read of that address returns the live upper count byte.

Top module: `xtc_counter_top`

## Requirements
- R1: After a synchronous reset the counter and all start bytes are zero, `tc` is 1 and `rd_data` is 0.
- R2: A write to address 0h sets the low start byte, 1h sets the middle start byte and Eh sets the upper start byte. Writes to any other address change nothing.
- R3: A command with bit 7 of `cmd_code` set loads the counter in one cycle. With `ext_en` high, all three start bytes are copied. With `ext_en` low, the lower two are copied and the upper counter byte is cleared.
- R4: Each `dec` pulse lowers the count by one. With `ext_en` low, only the lower 16 bits decrement and the upper byte is left unchanged. A load in the same cycle takes priority over `dec`.
- R5: A `dec` pulse is ignored when all active bits are zero (24 bits with `ext_en` high, the lower 16 otherwise).
- R6: `tc` is registered. It is 1 in the cycle after the active bits of the count become zero, and 0 otherwise.
- R7: A read of 0h or 1h returns the live low or middle count byte on `rd_data` one cycle after `rd_en`. A read of any address other than 0h, 1h or Eh returns 0.
- R8: A read of Eh returns `ID_CODE` (default 5Ah) when all three conditions hold: the DMA no-op code 80h has been issued since reset, `ext_en` is high, and Eh has not been written since reset.
- R9: Any write to Eh blocks the identification readback until the next reset. Reads of Eh then return the live upper count byte.
- R10: If no no-op has been issued since reset, or if `ext_en` is low, a read of Eh returns the live upper count byte.
- R11: `rd_data` holds its value in cycles with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Feature enable: 24-bit counting and identification readback |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Registered read data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code; bit 7 means a DMA command, 80h is the no-op |
| dec | input | 1 | One pulse per transferred byte |
| tc | output | 1 | Terminal count |

## Verification
The in-RTL assertions check the following on every cycle:
- the load copy;
- the single-step decrement of the lower 16 bits;
- the hold at zero;
- that the written and no-op flags are sticky;
- that a blocked or disabled read of Eh returns the upper count byte;
- that read data holds when there is no read.

Some behaviours only the bench's scenarios can show: the full three-way condition for the identification readback, its return after a fresh reset, terminal count with the upper byte still non-zero in 16-bit mode, and a long 24-bit countdown through a byte borrow. A behavioural model, driven by a long pseudo-random stimulus, compares `tc` and `rd_data` on every clock.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_EXT  = 2'd2,
    SEL_NONE = 2'd3
  } rsel_e;

  localparam int NUM_BYTES  = 3;
  localparam int BASE_BYTES = 2;
endpackage

// File: rtl/xtc_start_regs.sv
module xtc_start_regs
  import xtc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  rsel_e                   wr_sel,
  input  logic [DW-1:0]           wr_data,
  output logic [NUM_BYTES*DW-1:0] start_q,
  output logic                    ext_written
);
  // one register per start byte lane
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        start_q[g*DW +: DW] <= '0;
      else if (wr_en && wr_sel == rsel_e'(g))
        start_q[g*DW +: DW] <= wr_data;
    end
  end

  // sticky flag: upper byte written since reset
  always_ff @(posedge clk) begin
    if (rst)
      ext_written <= 1'b0;
    else if (wr_en && wr_sel == SEL_EXT)
      ext_written <= 1'b1;
  end

  assert_written_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ext_written |=> ext_written);
  assert_written_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_EXT) |=> ext_written);
  assert_lo_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_LO) |=> start_q[DW-1:0] == $past(wr_data));
endmodule

// File: rtl/xtc_count.sv
module xtc_count
  import xtc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    dec,
  input  logic                    ext_en,
  input  logic [NUM_BYTES*DW-1:0] start_q,
  output logic [NUM_BYTES*DW-1:0] cnt_q,
  output logic                    tc
);
  localparam int CW = NUM_BYTES * DW;
  localparam int BW = BASE_BYTES * DW;

  logic          active_zero;
  logic [CW-1:0] cnt_nxt;
  logic          tc_nxt;

  always_comb begin
    active_zero = ext_en ? (cnt_q == '0) : (cnt_q[BW-1:0] == '0);
    cnt_nxt     = cnt_q;
    if (load) begin
      if (ext_en) cnt_nxt = start_q;
      else        cnt_nxt = {{(CW-BW){1'b0}}, start_q[BW-1:0]};
    end else if (dec && !active_zero) begin
      if (ext_en) cnt_nxt = cnt_q - 1'b1;
      else        cnt_nxt = {cnt_q[CW-1:BW], cnt_q[BW-1:0] - 1'b1};
    end
    tc_nxt = ext_en ? (cnt_nxt == '0) : (cnt_nxt[BW-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tc    <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      tc    <= tc_nxt;
    end
  end

  assert_load_low_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q[BW-1:0] == $past(start_q[BW-1:0]));
  assert_load_short_R3: assert property (@(posedge clk) disable iff (rst)
    (load && !ext_en) |=> cnt_q[CW-1:BW] == '0);
  assert_dec_step_R4: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && !ext_en && cnt_q[BW-1:0] != '0)
    |=> cnt_q[BW-1:0] == BW'($past(cnt_q[BW-1:0]) - 1'b1));
  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && ext_en && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/xtc_readback.sv
module xtc_readback
  import xtc_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          CMDW     = 8,
  parameter logic [CMDW-1:0] NOP_CODE = 8'h80,
  parameter logic [DW-1:0]   ID_CODE  = 8'h5A
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  input  logic [CMDW-1:0]         cmd_code,
  input  logic                    ext_en,
  input  logic                    ext_written,
  input  logic                    rd_en,
  input  rsel_e                   rd_sel,
  input  logic [NUM_BYTES*DW-1:0] cnt_q,
  output logic [DW-1:0]           rd_data
);
  logic          nop_seen;
  logic          id_ok;
  logic [DW-1:0] rd_nxt;

  always_ff @(posedge clk) begin
    if (rst)
      nop_seen <= 1'b0;
    else if (cmd_valid && cmd_code == NOP_CODE)
      nop_seen <= 1'b1;
  end

  always_comb begin
    id_ok = nop_seen && ext_en && !ext_written;
    unique case (rd_sel)
      SEL_LO:  rd_nxt = cnt_q[0*DW +: DW];
      SEL_MID: rd_nxt = cnt_q[1*DW +: DW];
      SEL_EXT: rd_nxt = id_ok ? ID_CODE : cnt_q[2*DW +: DW];
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_nxt;
  end

  assert_nop_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    nop_seen |=> nop_seen);
  assert_blocked_id_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == SEL_EXT && ext_written) |=> rd_data == $past(cnt_q[2*DW +: DW]));
  assert_disabled_id_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == SEL_EXT && !ext_en) |=> rd_data == $past(cnt_q[2*DW +: DW]));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/xtc_counter_top.sv
module xtc_counter_top
  import xtc_pkg::*;
#(
  parameter int              DW        = 8,
  parameter int              AW        = 4,
  parameter int              CMDW      = 8,
  parameter logic [AW-1:0]   ADDR_LO   = 4'h0,
  parameter logic [AW-1:0]   ADDR_MID  = 4'h1,
  parameter logic [AW-1:0]   ADDR_EXT  = 4'hE,
  parameter logic [CMDW-1:0] NOP_CODE  = 8'h80,
  parameter logic [DW-1:0]   ID_CODE   = 8'h5A
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            cmd_valid,
  input  logic [CMDW-1:0] cmd_code,
  input  logic            dec,
  output logic            tc
);
  localparam int CW = NUM_BYTES * DW;

  function automatic rsel_e decode(input logic [AW-1:0] a);
    if (a == ADDR_LO)       return SEL_LO;
    else if (a == ADDR_MID) return SEL_MID;
    else if (a == ADDR_EXT) return SEL_EXT;
    else                    return SEL_NONE;
  endfunction

  rsel_e         wr_sel, rd_sel;
  logic          load;
  logic          ext_written;
  logic [CW-1:0] start_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    wr_sel = decode(wr_addr);
    rd_sel = decode(rd_addr);
    load   = cmd_valid && cmd_code[CMDW-1];
  end

  xtc_start_regs #(.DW(DW)) u_start (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start_q(start_q), .ext_written(ext_written)
  );

  xtc_count #(.DW(DW)) u_count (
    .clk(clk), .rst(rst), .load(load), .dec(dec), .ext_en(ext_en),
    .start_q(start_q), .cnt_q(cnt_q), .tc(tc)
  );

  xtc_readback #(.DW(DW), .CMDW(CMDW), .NOP_CODE(NOP_CODE), .ID_CODE(ID_CODE)) u_rb (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .ext_en(ext_en),
    .ext_written(ext_written), .rd_en(rd_en), .rd_sel(rd_sel), .cnt_q(cnt_q),
    .rd_data(rd_data)
  );

  assert_tc_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (tc && rd_data == '0));
endmodule

// File: tb/sim_xtc_counter_top.sv
`timescale 1ns/1ps
module sim_xtc_counter_top;
  localparam logic [7:0] ID = 8'h5A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       dec = 1'b0;
  logic       tc;

  always #4 clk = ~clk;

  xtc_counter_top u0 (
    .clk(clk), .rst(rst), .ext_en(ext_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .dec(dec), .tc(tc)
  );

  int vectors = 0;
  int fails = 0;
  string cur = "R1";

  // behavioural reference model
  int m_s0, m_s1, m_s2, m_cnt, m_rd;
  bit m_wr, m_nop, m_tc;

  always @(posedge clk) begin
    int nc;
    if (rst) begin
      m_s0 = 0; m_s1 = 0; m_s2 = 0; m_cnt = 0; m_rd = 0;
      m_wr = 0; m_nop = 0; m_tc = 1;
    end else begin
      if (rd_en) begin
        case (rd_addr)
          4'h0: m_rd = m_cnt & 255;
          4'h1: m_rd = (m_cnt >> 8) & 255;
          4'hE: m_rd = (!m_wr && m_nop && ext_en) ? int'(ID) : ((m_cnt >> 16) & 255);
          default: m_rd = 0;
        endcase
      end
      nc = m_cnt;
      if (cmd_valid && cmd_code[7])
        nc = ext_en ? ((m_s2 << 16) | (m_s1 << 8) | m_s0) : ((m_s1 << 8) | m_s0);
      else if (dec) begin
        if (ext_en) begin
          if (nc != 0) nc = nc - 1;
        end else if ((nc & 'hFFFF) != 0) nc = nc - 1;
      end
      m_cnt = nc;
      m_tc = ext_en ? (nc == 0) : ((nc & 'hFFFF) == 0);
      if (wr_en) begin
        if (wr_addr == 4'h0) m_s0 = int'(wr_data);
        if (wr_addr == 4'h1) m_s1 = int'(wr_data);
        if (wr_addr == 4'hE) begin m_s2 = int'(wr_data); m_wr = 1; end
      end
      if (cmd_valid && cmd_code == 8'h80) m_nop = 1;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; cmd_valid = 0; dec = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
    chk({cur, " tc"}, int'(tc), int'(m_tc));
    chk({cur, " rd_data"}, int'(rd_data), m_rd);
    idle();
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en = 1; rd_addr = a; step();
  endtask

  task automatic cmd(input logic [7:0] c);
    cmd_valid = 1; cmd_code = c; step();
  endtask

  task automatic decs(input int n);
    for (int i = 0; i < n; i++) begin dec = 1; step(); end
  endtask

  task automatic do_reset();
    rst = 1; step(); step(); rst = 0; step();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog R6: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int lf;
    #1;
    cur = "R1"; do_reset();
    chk("R1 reset tc", int'(tc), 1);
    chk("R1 reset rd_data", int'(rd_data), 0);

    cur = "R10"; ext_en = 1; rd(4'hE);
    chk("R10 no nop", int'(rd_data), 0);

    cur = "R8"; cmd(8'h80); rd(4'hE);
    chk("R8 id readback", int'(rd_data), int'(ID));

    cur = "R10"; ext_en = 0; rd(4'hE);
    chk("R10 ext_en low", int'(rd_data), 0);

    cur = "R2"; ext_en = 1; wr(4'h0, 8'h03); wr(4'h1, 8'h00); wr(4'hE, 8'h01); wr(4'h7, 8'hAA);
    cur = "R9"; rd(4'hE);
    chk("R9 id blocked", int'(rd_data), 0);
    cur = "R3"; cmd(8'h91);
    chk("R3 load tc", int'(tc), 0);
    cur = "R9"; rd(4'hE);
    chk("R9 upper byte", int'(rd_data), 1);
    cur = "R7"; rd(4'h0);
    chk("R7 low byte", int'(rd_data), 3);
    rd(4'h7);
    chk("R7 other addr", int'(rd_data), 0);

    cur = "R4"; decs(4);
    rd(4'h1); chk("R4 borrow mid", int'(rd_data), 8'hFF);
    rd(4'hE); chk("R4 borrow upper", int'(rd_data), 0);

    cur = "R3"; ext_en = 0; cmd(8'h91);
    rd(4'hE); chk("R3 short load upper", int'(rd_data), 0);
    cur = "R6"; decs(3);
    chk("R6 tc at zero", int'(tc), 1);
    cur = "R5"; decs(2);
    rd(4'h0); chk("R5 hold low", int'(rd_data), 0);
    rd(4'h1); chk("R5 hold mid", int'(rd_data), 0);

    cur = "R4"; cmd_valid = 1; cmd_code = 8'h91; dec = 1; step();
    rd(4'h0); chk("R4 load wins", int'(rd_data), 3);
    cur = "R11"; decs(1); step();
    chk("R11 hold", int'(rd_data), 3);

    cur = "R6"; ext_en = 1; cmd(8'h91); ext_en = 0; decs(3);
    chk("R6 tc short mode", int'(tc), 1);
    rd(4'hE); chk("R4 upper kept", int'(rd_data), 1);
    cur = "R5"; decs(1); rd(4'h0);
    chk("R5 short hold", int'(rd_data), 0);

    cur = "R8"; ext_en = 1; do_reset(); rd(4'hE);
    chk("R8 no nop after reset", int'(rd_data), 0);
    ext_en = 0; cmd(8'h80); ext_en = 1; rd(4'hE);
    chk("R8 id after reset", int'(rd_data), int'(ID));

    cur = "R6"; wr(4'h0, 8'h05); wr(4'h1, 8'h01); wr(4'hE, 8'h00); cmd(8'h91);
    decs(260); chk("R6 tc before end", int'(tc), 0);
    decs(1); chk("R6 tc at end", int'(tc), 1);

    cur = "R7"; lf = 32'h1ACE;
    for (int i = 0; i < 3000; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) != 0 ? 32'hB400 : 0);
      ext_en   = lf[9] | lf[10];
      dec      = lf[0] | lf[3];
      wr_en    = lf[1] & lf[4];
      wr_addr  = lf[5] ? 4'hE : (lf[6] ? 4'h1 : (lf[7] ? 4'h0 : 4'h3));
      wr_data  = 8'(lf >> 2) & 8'h07;
      rd_en    = lf[2];
      rd_addr  = lf[8] ? 4'hE : (lf[11] ? 4'h1 : (lf[12] ? 4'h0 : 4'h9));
      cmd_valid = (lf[13:11] == 3'b101);
      cmd_code = lf[14] ? 8'h80 : (lf[15] ? 8'h91 : 8'h12);
      if ((i % 997) == 996) rst = 1; else rst = 0;
      step();
    end
    rst = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule